// File: doc/BRIEF.md
# GPIO Pad Control Cell

This block sits between one pin's pad and the chip core. It holds a single 32-bit configuration word for the pin and turns it into the pad-side controls: the weak pull-up and pull-down enables, the drive-high and drive-low enables of the output stage, the hysteresis select and, for pins wired as I2C pins, the I2C speed class. The core supplies output data and output enable. It receives the pin level on the read path, inverted when the configuration asks for it.

A keeper mode steers the weak pulls to follow the last sensed pin level. The level first passes through a two-flop synchroniser. This holds an undriven input at the state it had last.

A parameter selects an I2C-pin variant. That variant has a different set of writable fields, no pull or open-drain fields, and an output stage that can only pull low. Software reaches the word through a minimal select/write-enable bus. Writes take effect only while the block's configuration clock enable is high.

Top module: `pad_cfg_cell`

## Requirements
- R1: After reset, a read of the standard variant returns 0x0000_0088. This is pull-up mode in bits [4:3], hysteresis, inversion and open-drain all 0, and reserved bit 7 reading 1. `pad_pu_en` is 1 and `pad_pd_en` is 0.
- R2: Bits [4:3] select the pull mode in the standard variant. 0 turns both pulls off, 1 enables only the pull-up and 2 enables only the pull-down. The pulls change on the clock edge that accepts the write.
- R3: With bits [4:3] = 3 (keeper), `pad_pu_en` equals the pin level sampled two rising edges earlier, and `pad_pd_en` is its complement. After reset the keeper level starts at 1.
- R4: `pad_pu_en` and `pad_pd_en` are never high together.
- R5: Bit 5 drives `pad_hys_en` in the standard variant.
- R6: `core_din` equals `pad_in` when bit 6 is 0 and its inverse when bit 6 is 1, with no clock delay.
- R7: With `core_oe` low, both `pad_drv_hi` and `pad_drv_lo` are 0. With `core_oe` high, data 0 enables `pad_drv_lo` only. Data 1 enables `pad_drv_hi` only, or neither driver when bit 10 (open-drain) is 1.
- R8: A write while `cfg_clk_en` is low leaves the stored word unchanged.
- R9: Reserved bits ignore written data and always read back their reset values: bit 7 reads 1, and every other reserved bit reads 0.
- R10: `bus_rdata` is 0 whenever the cycle is not a read (`bus_sel` low or `bus_we` high).
- R11: In the I2C variant, bits [9:8] hold the mode: 0 = standard/fast, 1 = plain GPIO needing an external pull-up, 2 = fast-mode-plus, 3 = reserved. Reset reads 0x0000_0080. The writable bits are 6, 8 and 9. Both pulls stay off, `pad_drv_hi` stays 0, and `pad_i2c_mode` mirrors bits [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Configuration clock enable; writes are accepted only while high |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside read cycles |
| core_dout | input | 1 | Output data from the core |
| core_oe | input | 1 | Output enable from the core |
| core_din | output | 1 | Pin level to the core, optionally inverted |
| pad_in | input | 1 | Level sensed at the pad |
| pad_pu_en | output | 1 | Weak pull-up enable |
| pad_pd_en | output | 1 | Weak pull-down enable |
| pad_drv_hi | output | 1 | Strong high driver enable |
| pad_drv_lo | output | 1 | Strong low driver enable |
| pad_hys_en | output | 1 | Input hysteresis select |
| pad_i2c_mode | output | 2 | I2C speed class (I2C variant only, else 0) |

## Verification
The assertions assume a few things about the inputs. `pad_in` is a settled two-level signal at each rising edge. `bus_sel`, `bus_we` and `cfg_clk_en` change only away from the edge. Reset is held long enough for the synchroniser to be cleared. The bench respects all of this: it changes every input on the falling edge, keeps `pad_in` at a defined 0 or 1 throughout, and holds reset for several cycles. It also waits at least two rising edges before it checks the keeper's reaction to a new pin level, because the synchroniser delays that reaction.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

   typedef enum logic [1:0] {
      PULL_NONE = 2'd0,
      PULL_UP   = 2'd1,
      PULL_DOWN = 2'd2,
      PULL_KEEP = 2'd3
   } pull_mode_e;

   typedef enum logic [1:0] {
      I2C_STD_FAST = 2'd0,
      I2C_AS_GPIO  = 2'd1,
      I2C_FM_PLUS  = 2'd2,
      I2C_RSVD     = 2'd3
   } i2c_mode_e;

   // Field positions inside the configuration word
   localparam int unsigned PULL_LSB = 3;
   localparam int unsigned HYS_BIT  = 5;
   localparam int unsigned INV_BIT  = 6;
   localparam int unsigned I2C_LSB  = 8;
   localparam int unsigned OD_BIT   = 10;
   localparam int unsigned MIN_W    = 11;

   typedef struct packed {
      pull_mode_e pull;
      logic       hys;
      logic       inv;
      logic       od;
      i2c_mode_e  i2c;
   } pad_cfg_t;

endpackage

// File: rtl/pad_cfg_reg.sv
module pad_cfg_reg
   import pad_cfg_pkg::*;
#(
   parameter int unsigned      DATA_W        = 32,
   parameter bit               I2C_PIN       = 1'b0,
   parameter logic [DATA_W-1:0] RSVD_ONE_MASK = DATA_W'(32'h0000_0080)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              sel,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] word_q,
   output pad_cfg_t          cfg
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   localparam logic [DATA_W-1:0] WMASK_STD =
      (DATA_W'(3) << PULL_LSB) | (ONE << HYS_BIT) | (ONE << INV_BIT) | (ONE << OD_BIT);
   localparam logic [DATA_W-1:0] WMASK_I2C =
      (ONE << INV_BIT) | (DATA_W'(3) << I2C_LSB);
   localparam logic [DATA_W-1:0] WMASK = I2C_PIN ? WMASK_I2C : WMASK_STD;
   localparam logic [DATA_W-1:0] RST_FIELDS =
      I2C_PIN ? '0 : (DATA_W'(PULL_UP) << PULL_LSB);
   localparam logic [DATA_W-1:0] RST_VAL = RST_FIELDS | RSVD_ONE_MASK;

   if (DATA_W < MIN_W) begin : g_bad_width
      $error("pad_cfg_reg: DATA_W too small for the field layout");
   end
   if ((RSVD_ONE_MASK & WMASK) != '0) begin : g_bad_mask
      $error("pad_cfg_reg: reserved-one mask overlaps a writable field");
   end

   logic wr_fire;
   assign wr_fire = sel & we & clk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= RST_VAL;
      end else if (wr_fire) begin
         word_q <= (wdata & WMASK) | (RST_VAL & ~WMASK);
      end
   end

   assign rdata = (sel && !we) ? word_q : '0;

   always_comb begin
      cfg      = '0;
      cfg.inv  = word_q[INV_BIT];
      if (I2C_PIN) begin
         cfg.i2c = i2c_mode_e'(word_q[I2C_LSB +: 2]);
      end else begin
         cfg.pull = pull_mode_e'(word_q[PULL_LSB +: 2]);
         cfg.hys  = word_q[HYS_BIT];
         cfg.od   = word_q[OD_BIT];
      end
   end

endmodule

// File: rtl/pad_keeper_sync.sv
module pad_keeper_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RST_LVL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_lvl,
   output logic held_lvl
);

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("pad_keeper_sync: at least two stages required");
   end

   logic [SYNC_STAGES-1:0] stage_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_LVL;
            else        stage_q[s] <= pin_lvl;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_LVL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign held_lvl = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
   import pad_cfg_pkg::*;
#(
   parameter bit I2C_PIN = 1'b0
) (
   input  pull_mode_e mode,
   input  logic       keep_lvl,
   output logic       pu_en,
   output logic       pd_en
);

   if (I2C_PIN) begin : g_i2c
      assign pu_en = 1'b0;
      assign pd_en = 1'b0;
   end else begin : g_std
      always_comb begin
         pu_en = 1'b0;
         pd_en = 1'b0;
         unique case (mode)
            PULL_NONE: ;
            PULL_UP:   pu_en = 1'b1;
            PULL_DOWN: pd_en = 1'b1;
            PULL_KEEP: begin
               pu_en = keep_lvl;
               pd_en = ~keep_lvl;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pad_drv_ctrl.sv
module pad_drv_ctrl #(
   parameter bit I2C_PIN = 1'b0
) (
   input  logic oe,
   input  logic dout,
   input  logic od,
   input  logic inv,
   input  logic pin_lvl,
   output logic drv_hi,
   output logic drv_lo,
   output logic din
);

   logic od_eff;

   if (I2C_PIN) begin : g_true_od
      assign od_eff = 1'b1;
   end else begin : g_cfg_od
      assign od_eff = od;
   end

   assign drv_lo = oe & ~dout;
   assign drv_hi = oe & dout & ~od_eff;
   assign din    = pin_lvl ^ inv;

endmodule

// File: rtl/pad_cfg_cell.sv
module pad_cfg_cell
   import pad_cfg_pkg::*;
#(
   parameter int unsigned      DATA_W        = 32,
   parameter bit               I2C_PIN       = 1'b0,
   parameter int unsigned      SYNC_STAGES   = 2,
   parameter logic [DATA_W-1:0] RSVD_ONE_MASK = DATA_W'(32'h0000_0080)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_clk_en,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_dout,
   input  logic              core_oe,
   output logic              core_din,
   input  logic              pad_in,
   output logic              pad_pu_en,
   output logic              pad_pd_en,
   output logic              pad_drv_hi,
   output logic              pad_drv_lo,
   output logic              pad_hys_en,
   output logic [1:0]        pad_i2c_mode
);

   pad_cfg_t          cfg;
   logic [DATA_W-1:0] cfg_q;
   logic              keep_lvl;

   pad_cfg_reg #(
      .DATA_W       (DATA_W),
      .I2C_PIN      (I2C_PIN),
      .RSVD_ONE_MASK(RSVD_ONE_MASK)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clk_en (cfg_clk_en),
      .sel    (bus_sel),
      .we     (bus_we),
      .wdata  (bus_wdata),
      .rdata  (bus_rdata),
      .word_q (cfg_q),
      .cfg    (cfg)
   );

   pad_keeper_sync #(
      .SYNC_STAGES(SYNC_STAGES),
      .RST_LVL    (1'b1)
   ) u_keep (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_lvl  (pad_in),
      .held_lvl (keep_lvl)
   );

   pad_pull_ctrl #(
      .I2C_PIN(I2C_PIN)
   ) u_pull (
      .mode     (cfg.pull),
      .keep_lvl (keep_lvl),
      .pu_en    (pad_pu_en),
      .pd_en    (pad_pd_en)
   );

   pad_drv_ctrl #(
      .I2C_PIN(I2C_PIN)
   ) u_drv (
      .oe      (core_oe),
      .dout    (core_dout),
      .od      (cfg.od),
      .inv     (cfg.inv),
      .pin_lvl (pad_in),
      .drv_hi  (pad_drv_hi),
      .drv_lo  (pad_drv_lo),
      .din     (core_din)
   );

   if (I2C_PIN) begin : g_i2c_out
      assign pad_hys_en   = 1'b0;
      assign pad_i2c_mode = cfg.i2c;
   end else begin : g_std_out
      assign pad_hys_en   = cfg.hys;
      assign pad_i2c_mode = 2'b00;
   end

endmodule

// File: rtl/pad_cfg_chk.sv
module pad_cfg_chk #(
   parameter int unsigned      DATA_W        = 32,
   parameter bit               I2C_PIN       = 1'b0,
   parameter int unsigned      SYNC_STAGES   = 2,
   parameter logic [DATA_W-1:0] RSVD_ONE_MASK = DATA_W'(32'h0000_0080)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_clk_en,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] cfg_q,
   input logic              pad_in,
   input logic              core_oe,
   input logic              pad_pu_en,
   input logic              pad_pd_en,
   input logic              pad_drv_hi,
   input logic              pad_drv_lo
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R4
   p_pull_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu_en && pad_pd_en));

   // R7
   p_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !core_oe |-> (!pad_drv_hi && !pad_drv_lo));

   p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (I2C_PIN || cfg_q[10]) |-> !pad_drv_hi);

   // R8
   p_gated_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_clk_en |=> $stable(cfg_q));

   // R9
   p_rsvd_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we) |-> ((bus_rdata & RSVD_ONE_MASK) == RSVD_ONE_MASK));

   // R10
   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel || bus_we) |-> (bus_rdata == '0));

   if (I2C_PIN) begin : g_i2c_chk
      // R11
      p_i2c_no_pull_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !pad_pu_en && !pad_pd_en);
   end else if (SYNC_STAGES == 2) begin : g_keep_chk
      // R3
      p_keeper_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[4:3] == 2'b11 && since_rst == 2'd3)
            |-> (pad_pu_en == $past(pad_in, 2) && pad_pd_en == !$past(pad_in, 2)));
   end

endmodule

bind pad_cfg_cell pad_cfg_chk #(
   .DATA_W       (DATA_W),
   .I2C_PIN      (I2C_PIN),
   .SYNC_STAGES  (SYNC_STAGES),
   .RSVD_ONE_MASK(RSVD_ONE_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_clk_en (cfg_clk_en),
   .bus_sel    (bus_sel),
   .bus_we     (bus_we),
   .bus_rdata  (bus_rdata),
   .cfg_q      (cfg_q),
   .pad_in     (pad_in),
   .core_oe    (core_oe),
   .pad_pu_en  (pad_pu_en),
   .pad_pd_en  (pad_pd_en),
   .pad_drv_hi (pad_drv_hi),
   .pad_drv_lo (pad_drv_lo)
);

// File: tb/sim_pad_cfg_cell.sv
`timescale 1ns/1ps
module sim_pad_cfg_cell;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_clk_en = 1'b1;
   logic        sel0 = 1'b0, sel1 = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic        core_dout = 1'b0, core_oe = 1'b0;
   logic        pad_in = 1'b1;
   logic        din0, pu0, pd0, hi0, lo0, hys0;
   logic        din1, pu1, pd1, hi1, lo1, hys1;
   logic [1:0]  i2c0, i2c1;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pad_cfg_cell #(.I2C_PIN(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_clk_en(cfg_clk_en),
      .bus_sel(sel0), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata0),
      .core_dout(core_dout), .core_oe(core_oe), .core_din(din0),
      .pad_in(pad_in), .pad_pu_en(pu0), .pad_pd_en(pd0),
      .pad_drv_hi(hi0), .pad_drv_lo(lo0), .pad_hys_en(hys0), .pad_i2c_mode(i2c0)
   );

   pad_cfg_cell #(.I2C_PIN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_clk_en(cfg_clk_en),
      .bus_sel(sel1), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata1),
      .core_dout(core_dout), .core_oe(core_oe), .core_din(din1),
      .pad_in(pad_in), .pad_pu_en(pu1), .pad_pd_en(pd1),
      .pad_drv_hi(hi1), .pad_drv_lo(lo1), .pad_hys_en(hys1), .pad_i2c_mode(i2c1)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input bit which, input logic [31:0] d);
      @(negedge clk);
      if (which) sel1 = 1'b1; else sel0 = 1'b1;
      we = 1'b1;
      wdata = d;
      @(negedge clk);
      sel0 = 1'b0; sel1 = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input bit which, output logic [31:0] d);
      @(negedge clk);
      if (which) sel1 = 1'b1; else sel0 = 1'b1;
      we = 1'b0;
      #1;
      d = which ? rdata1 : rdata0;
      sel0 = 1'b0; sel1 = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(1'b0, v);
      check("R1 reset word", v, 32'h88);
      check("R1 reset pull-up", {pu0, pd0}, 2'b10);
      rd(1'b1, v);
      check("R11 i2c reset word", v, 32'h80);
      check("R11 i2c reset mode", i2c1, 2'd0);
   endtask

   task automatic t_pull_modes();
      wr(1'b0, 32'h00);
      check("R2 no pull", {pu0, pd0}, 2'b00);
      wr(1'b0, 32'h10);
      check("R2 pull-down", {pu0, pd0}, 2'b01);
      wr(1'b0, 32'h08);
      check("R2 pull-up", {pu0, pd0}, 2'b10);
   endtask

   task automatic t_repeater();
      pad_in = 1'b1;
      wr(1'b0, 32'h18);
      @(negedge clk);
      check("R3 keeper high", {pu0, pd0}, 2'b10);
      pad_in = 1'b0;
      @(negedge clk);
      check("R3 keeper one edge later", {pu0, pd0}, 2'b10);
      @(negedge clk);
      check("R3 keeper low after two edges", {pu0, pd0}, 2'b01);
      pad_in = 1'b1;
      repeat (2) @(negedge clk);
      check("R3 keeper back high", {pu0, pd0}, 2'b10);
      check("R4 pulls exclusive", 32'(pu0 & pd0), 32'd0);
   endtask

   task automatic t_hys_inv();
      wr(1'b0, 32'h00);
      pad_in = 1'b1; #1;
      check("R6 no invert", din0, 1'b1);
      wr(1'b0, 32'h60);
      check("R5 hysteresis on", hys0, 1'b1);
      pad_in = 1'b1; #1;
      check("R6 invert high", din0, 1'b0);
      pad_in = 1'b0; #1;
      check("R6 invert low", din0, 1'b1);
      pad_in = 1'b1;
   endtask

   task automatic t_output();
      wr(1'b0, 32'h00);
      @(negedge clk);
      core_oe = 1'b0; core_dout = 1'b1; #1;
      check("R7 tristate", {hi0, lo0}, 2'b00);
      core_oe = 1'b1; core_dout = 1'b0; #1;
      check("R7 drive low", {hi0, lo0}, 2'b01);
      core_dout = 1'b1; #1;
      check("R7 drive high", {hi0, lo0}, 2'b10);
      wr(1'b0, 32'h400);
      check("R7 open-drain high released", {hi0, lo0}, 2'b00);
      core_dout = 1'b0; #1;
      check("R7 open-drain low", {hi0, lo0}, 2'b01);
      core_oe = 1'b0;
   endtask

   task automatic t_gate();
      logic [31:0] v;
      wr(1'b0, 32'h08);
      @(negedge clk);
      cfg_clk_en = 1'b0;
      wr(1'b0, 32'h10);
      rd(1'b0, v);
      check("R8 gated write ignored", v, 32'h88);
      check("R8 pulls unchanged", {pu0, pd0}, 2'b10);
      cfg_clk_en = 1'b1;
   endtask

   task automatic t_rsvd();
      logic [31:0] v;
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, v);
      check("R9 all ones", v, 32'h4F8);
      wr(1'b0, 32'h0);
      rd(1'b0, v);
      check("R9 all zeros keeps bit7", v, 32'h80);
   endtask

   task automatic t_idle();
      @(negedge clk);
      sel0 = 1'b0; we = 1'b0; #1;
      check("R10 idle rdata", rdata0, 32'h0);
      sel0 = 1'b1; we = 1'b1; wdata = 32'h08; #1;
      check("R10 write-cycle rdata", rdata0, 32'h0);
      @(negedge clk);
      sel0 = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic t_i2c();
      logic [31:0] v;
      wr(1'b1, 32'h200);
      check("R11 fm-plus mode", i2c1, 2'd2);
      rd(1'b1, v);
      check("R11 mode readback", v, 32'h280);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v);
      check("R11 writable bits", v, 32'h3C0);
      check("R11 pulls off", {pu1, pd1}, 2'b00);
      core_oe = 1'b1; core_dout = 1'b1; #1;
      check("R11 no high drive", {hi1, lo1}, 2'b00);
      core_dout = 1'b0; #1;
      check("R11 low drive", {hi1, lo1}, 2'b01);
      core_oe = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pull_modes();
      t_repeater();
      t_hys_inv();
      t_output();
      t_gate();
      t_rsvd();
      t_idle();
      t_i2c();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule